// File: doc/BRIEF.md
# Queue Time-Slice Gate Scheduler

This block produces one transmit-permission gate for each of four transmit queues. Every queue owns a free-running microsecond counter with a programmable period. Inside that period a programmable window decides when the queue may send. A transmit arbiter downstream reads the four gates and lets only the open queues compete for the channel.

Software sets three values per queue through a write-strobe configuration port: the period limit, the window start and the window end. The target queue is named in the upper field of the write data. A separate control write can hold every counter at zero and release them together, so that the four schedules line up. After reset every queue repeats a 50000 µs period with its window covering all of it, so all four gates are open.

Top module: `tslice_gate_sched`

## Requirements
- R1: After reset every queue has period limit 49999, window start 0, window end 49999 and a counter at 0, so `gate_o` reads 4'hF and stays 4'hF while ticks arrive.
- R2: A queue counter advances by one only in a clock cycle where `us_tick` is 1. Without a tick it holds its value, and so does the gate.
- R3: A counter that sees a tick while its value is greater than or equal to its period limit goes to 0. The period is therefore limit plus one ticks.
- R4: `gate_o[q]` is 1 exactly when start ≤ counter ≤ end for queue q, with both bounds included. When start is greater than end the gate stays 0.
- R5: `cfg_wdata[31:20]` holds the queue index and `cfg_wdata[19:0]` holds the value. `cfg_sel` picks the target: 0 = period limit, 1 = window start, 2 = window end. A write with index 4 or above, or with `cfg_sel` = 3, changes nothing.
- R6: A configuration write takes effect from the next clock and does not disturb the queue counter.
- R7: While the stored control bit `ctrl_wdata[7]` is 1, all four counters are held at 0. Writing 0 releases them in the same cycle. A control write with bit 7 clear only releases; it never restarts a running counter.
- R8: The queues are independent. Writing or running one queue does not change another queue's gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Parameter select: 0 period, 1 start, 2 end, 3 reserved |
| cfg_wdata | input | 32 | Queue index [31:20], value [19:0] |
| ctrl_wr_en | input | 1 | Control write strobe |
| ctrl_wdata | input | 32 | Control data; bit 7 is the counter hold |
| gate_o | output | 4 | Per-queue transmit gate, bit q for queue q |

## Verification
The assertions check every cycle that a counter steps by one only on a tick and wraps at its limit. They also check that the hold bit forces all counters to zero, that rejected writes (bad index or reserved select) leave the configuration untouched, and that a gate is never open below its start or with an inverted window. Only the bench's scenarios can show the behaviour seen from outside. The bench recovers counter positions from window edges at the ports. From those it shows the exact tick on which a narrow window opens, that a live write moves a window without restarting the count, and that four queues with different periods open on the same tick after a synchronized release.

// File: rtl/tsg_pkg.sv
// Package: shared constants and types for the queue time-slice gate scheduler.
// Assumes four queues and 20-bit microsecond counts.
package tsg_pkg;
    localparam int NUM_Q    = 4;
    localparam int CNT_W    = 20;
    localparam int QIDX_LSB = 20;
    localparam int SYNC_BIT = 7;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_START  = 2'd1,
        SEL_END    = 2'd2,
        SEL_RSVD   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        cnt_t period;
        cnt_t start;
        cnt_t stop;
    } qcfg_t;
endpackage

// File: rtl/tsg_cfg_regs.sv
// Module: configuration and control registers for all queues.
// Decodes the queue index from the upper data field and the parameter from
// cfg_sel, and keeps the shared counter-hold bit. Writes land on the next edge.
// Assumes: DATA_W > QIDX_LSB, and the defaults fit in CNT_W bits.
module tsg_cfg_regs
    import tsg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEF_PERIOD = 49999,
    parameter int DEF_START  = 0,
    parameter int DEF_END    = 49999
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr_en,
    input  logic [1:0]              cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    input  logic                    ctrl_wr_en,
    input  logic [DATA_W-1:0]       ctrl_wdata,
    output qcfg_t [NUM_Q-1:0]       cfg_o,
    output logic                    hold_o
);
    localparam int IDX_W = DATA_W - QIDX_LSB;

    logic [IDX_W-1:0] wr_idx;
    cnt_t             wr_val;
    logic             idx_ok;
    cfg_sel_e         sel;
    logic [NUM_Q-1:0] wr_q;
    qcfg_t [NUM_Q-1:0] cfg_q;
    logic             hold_q;

    // Split the write data into queue index and value fields.
    always_comb begin
        wr_idx = cfg_wdata[DATA_W-1:QIDX_LSB];
        wr_val = cfg_wdata[CNT_W-1:0];
        idx_ok = (wr_idx < IDX_W'(NUM_Q));
        sel    = cfg_sel_e'(cfg_sel);
    end

    // Shared counter-hold bit, set or cleared by each control write.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= 1'b0;
        else if (ctrl_wr_en) hold_q <= ctrl_wdata[SYNC_BIT];
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        // Write enable for this queue alone.
        assign wr_q[g] = cfg_wr_en && idx_ok && (wr_idx == IDX_W'(g));

        // Per-queue parameter storage, loaded with the open schedule on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g].period <= CNT_W'(DEF_PERIOD);
                cfg_q[g].start  <= CNT_W'(DEF_START);
                cfg_q[g].stop   <= CNT_W'(DEF_END);
            end else if (wr_q[g]) begin
                case (sel)
                    SEL_PERIOD: cfg_q[g].period <= wr_val;
                    SEL_START:  cfg_q[g].start  <= wr_val;
                    SEL_END:    cfg_q[g].stop   <= wr_val;
                    default:    ;
                endcase
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign hold_o = hold_q;

    AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !idx_ok) |=> $stable(cfg_q)); // R5
    AST_RSVD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_sel == 2'd3) |=> $stable(cfg_q)); // R5
    AST_WR_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_q)); // R8
endmodule

// File: rtl/tsg_slot_counter.sv
// Module: one queue's microsecond counter.
// Counts ticks from 0 up to its period limit, then returns to 0. A shared hold
// forces it to 0. Parameter writes never touch it.
// Assumes: us_tick is a single-cycle pulse.
module tsg_slot_counter
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic hold,
    input  cnt_t period,
    output cnt_t cnt_o
);
    cnt_t cnt_q;

    // Advance on tick, wrap at or beyond the limit, clear while held.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (hold)    cnt_q <= '0;
        else if (us_tick) cnt_q <= (cnt_q >= period) ? '0 : cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !hold) |=> $stable(cnt_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && !hold && cnt_q < period) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && !hold && cnt_q >= period) |=> (cnt_q == '0)); // R3
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/tsg_gate_cmp.sv
// Module: window comparator for one queue.
// Opens the gate while the counter lies within [start, stop], both bounds
// included. An inverted window (start > stop) never opens.
// Assumes: inputs come straight from registers, so the output is glitch-safe
// within the cycle.
module tsg_gate_cmp
    import tsg_pkg::*;
(
    input  cnt_t cnt,
    input  cnt_t start,
    input  cnt_t stop,
    output logic gate
);
    // Inclusive window test.
    always_comb gate = (cnt >= start) && (cnt <= stop);
endmodule

// File: rtl/tslice_gate_sched.sv
// Module: top of the queue time-slice gate scheduler.
// Holds four independent period counters, each with its own open window, and
// drives one transmit gate per queue. A control bit aligns all counters.
// Assumes: us_tick pulses once per microsecond in the clk domain.
module tslice_gate_sched
    import tsg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEF_PERIOD = 49999,
    parameter int DEF_START  = 0,
    parameter int DEF_END    = 49999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ctrl_wr_en,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic [NUM_Q-1:0]  gate_o
);
    qcfg_t [NUM_Q-1:0] qcfg;
    logic              hold;
    cnt_t [NUM_Q-1:0]  cnt;

    tsg_cfg_regs #(
        .DATA_W     (DATA_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_START  (DEF_START),
        .DEF_END    (DEF_END)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ctrl_wr_en (ctrl_wr_en),
        .ctrl_wdata (ctrl_wdata),
        .cfg_o      (qcfg),
        .hold_o     (hold)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_lane
        tsg_slot_counter u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .us_tick (us_tick),
            .hold    (hold),
            .period  (qcfg[g].period),
            .cnt_o   (cnt[g])
        );

        tsg_gate_cmp u_cmp (
            .cnt   (cnt[g]),
            .start (qcfg[g].start),
            .stop  (qcfg[g].stop),
            .gate  (gate_o[g])
        );

        AST_INVERTED_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
            (qcfg[g].start > qcfg[g].stop) |-> !gate_o[g]); // R4
        AST_BELOW_START_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] < qcfg[g].start) |-> !gate_o[g]); // R4
        AST_ALIGNED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hold) |-> (cnt[g] == '0)); // R7
    end
endmodule

// File: tb/tslice_gate_sched_tb.sv
// Directed bench for the queue time-slice gate scheduler. Inputs change on the
// falling edge and outputs are sampled on the falling edge.
module tslice_gate_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        ctrl_wr_en = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [3:0]  gate_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    tslice_gate_sched u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ctrl_wr_en (ctrl_wr_en),
        .ctrl_wdata (ctrl_wdata),
        .gate_o     (gate_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gate got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gate bit got %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic cfg_write(input int q, input logic [1:0] sel, input int val);
        cfg_wr_en = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = {12'(q), 20'(val)};
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ctrl_write(input logic [31:0] val);
        ctrl_wr_en = 1'b1;
        ctrl_wdata = val;
        @(negedge clk);
        ctrl_wr_en = 1'b0;
    endtask

    task automatic sync_pulse();
        ctrl_write(32'h0000_0080);
        ctrl_write(32'h0000_0000);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset open", gate_o, 4'hF);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1 default stays open", gate_o, 4'hF);
        end
    endtask

    task automatic t_window();
        int c = 0;
        cfg_write(0, 2'd0, 9);
        cfg_write(0, 2'd1, 3);
        cfg_write(0, 2'd2, 5);
        sync_pulse();
        chk1("R4 closed at count 0", gate_o[0], 1'b0);
        for (int i = 0; i < 25; i++) begin
            tick();
            c = (c >= 9) ? 0 : c + 1;
            chk1("R3 R4 window position", gate_o[0], (c >= 3 && c <= 5));
            idle(2);
            chk1("R2 no tick holds", gate_o[0], (c >= 3 && c <= 5));
            chk("R8 other queues open", gate_o[3:1], 3'b111);
        end
    endtask

    task automatic t_inverted();
        cfg_write(2, 2'd1, 7);
        cfg_write(2, 2'd2, 3);
        sync_pulse();
        for (int i = 0; i < 12; i++) begin
            chk1("R4 inverted window shut", gate_o[2], 1'b0);
            tick();
        end
        cfg_write(2, 2'd1, 0);
        cfg_write(2, 2'd2, 49999);
        chk1("R4 restored window open", gate_o[2], 1'b1);
    endtask

    task automatic t_bad_index();
        int c = 0;
        sync_pulse();
        cfg_write(4, 2'd1, 100);
        cfg_write(7, 2'd2, 0);
        cfg_write(0, 2'd3, 0);
        cfg_write(4095, 2'd0, 2);
        for (int i = 0; i < 12; i++) begin
            tick();
            c = (c >= 9) ? 0 : c + 1;
            chk1("R5 queue0 unchanged by ignored writes", gate_o[0], (c >= 3 && c <= 5));
            chk1("R5 queue3 unchanged by ignored writes", gate_o[3], 1'b1);
        end
    endtask

    task automatic t_live_write();
        cfg_write(1, 2'd0, 99);
        cfg_write(1, 2'd1, 50);
        cfg_write(1, 2'd2, 50);
        sync_pulse();
        for (int i = 0; i < 10; i++) tick();
        chk1("R6 window closed at 10", gate_o[1], 1'b0);
        cfg_write(1, 2'd1, 12);
        cfg_write(1, 2'd2, 12);
        chk1("R6 still closed at 10 after write", gate_o[1], 1'b0);
        tick();
        chk1("R6 count 11 closed", gate_o[1], 1'b0);
        tick();
        chk1("R6 count 12 open, counter kept", gate_o[1], 1'b1);
        tick();
        chk1("R6 count 13 closed", gate_o[1], 1'b0);
    endtask

    task automatic t_sync();
        cfg_write(0, 2'd0, 9);
        cfg_write(1, 2'd0, 20);
        cfg_write(2, 2'd0, 30);
        cfg_write(3, 2'd0, 40);
        for (int q = 0; q < 4; q++) begin
            cfg_write(q, 2'd1, 1);
            cfg_write(q, 2'd2, 1);
        end
        for (int i = 0; i < 3; i++) tick();
        ctrl_write(32'h0000_0080);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R7 held at zero", gate_o, 4'h0);
        end
        ctrl_write(32'h0000_0000);
        chk("R7 released at zero", gate_o, 4'h0);
        tick();
        chk("R7 aligned at count 1", gate_o, 4'hF);
        tick();
        chk("R7 aligned past window", gate_o, 4'h0);
        ctrl_write(32'hFFFF_FF7F);
        tick();
        chk("R7 clear-bit write keeps count", gate_o, 4'h0);
        for (int i = 0; i < 7; i++) tick();
        chk("R3 queue0 wrapped to 0", gate_o, 4'h0);
        tick();
        chk("R3 queue0 alone at 1", gate_o, 4'h1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(1);
        t_reset();
        t_window();
        t_inverted();
        t_bad_index();
        t_live_write();
        t_sync();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule